// File: doc/BRIEF.md
# Operation Sampling Interval Selector

This block decides which decoded pipeline operations are picked for profiling. A down-counter is loaded from a programmable interval. Every decode strobe steps it down by one. When the count runs out, the operation decoded in that cycle is tagged. The reload value can be widened by a pseudo-random offset, so that a tight loop does not hand back the same instruction on every pick.

A tagged operation is followed until a retire strobe with its identifier arrives. While it is pending, a latency counter runs. At retirement the block compares the latency with a programmable minimum. If the latency reaches that minimum, it emits an accepted-sample pulse that carries the identifier, the latency and the retire event bits. Otherwise it emits a discard pulse that carries the same fields. Only one operation can be pending at a time. A pick that arrives while the slot is occupied is dropped and counted. Record formatting, memory traffic and the pipeline itself lie outside this block.

Top module: `op_sample_sel`

## Requirements
- R1: With `cfg_pert_w` = 0 and the slot free, every N-th decode is selected, where N is `cfg_interval` and a value of 0 counts as 1. One cycle after the selecting decode, `tag_vld` pulses with `tag_id` equal to that decode's `dec_id`.
- R2: Cycles in which `dec_vld` is low leave the interval count unchanged.
- R3: Each reload adds the low `cfg_pert_w` bits of a 16-bit LFSR to the interval, with the width capped at `MAX_PERT_W`. With interval N and width w, the spacing between picks lies in [N, N+2^w-1] and is not constant.
- R4: The reported latency equals the number of clock edges from the selecting decode to the matching retire, and is therefore at least 1. A retire whose `ret_id` differs from the tracked identifier is ignored.
- R5: At a matching retire, latency >= `cfg_min_lat` gives an `smp_vld` pulse, and anything lower gives a `disc_vld` pulse. Either pulse appears one cycle after the retire, with `smp_id`, `smp_lat` and `smp_evt` (equal to `ret_evt`) valid alongside it.
- R6: A selection that occurs while an operation is pending and not retiring produces no tag and increments `col_cnt` by one, saturating at its maximum.
- R7: When the pending operation retires in the same cycle as a new selection, the new operation is accepted and tagged.
- R8: While `en` is low, the pending operation is cancelled, the counter is reloaded and no pulse is produced. A later retire of the cancelled identifier produces nothing.
- R9: After reset all pulse outputs are low, `col_cnt` is 0 and the counter holds the reload value.
- R10: `smp_vld` and `disc_vld` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Sampling enable; low cancels and reloads |
| cfg_interval | input | IVL_W | Base pick interval in decodes (0 treated as 1) |
| cfg_pert_w | input | PW_W | Number of random bits added at reload |
| cfg_min_lat | input | LAT_W | Minimum latency for an accepted sample |
| dec_vld | input | 1 | Decoded-operation strobe |
| dec_id | input | ID_W | Identifier of the decoded operation |
| ret_vld | input | 1 | Retire strobe |
| ret_id | input | ID_W | Identifier of the retiring operation |
| ret_evt | input | EVT_W | Event flags of the retiring operation |
| tag_vld | output | 1 | Pulse: an operation was tagged |
| tag_id | output | ID_W | Identifier of the tagged operation |
| smp_vld | output | 1 | Pulse: sample passed the filter |
| disc_vld | output | 1 | Pulse: sample failed the filter |
| smp_id | output | ID_W | Identifier of the finished sample |
| smp_lat | output | LAT_W | Latency of the finished sample |
| smp_evt | output | EVT_W | Event flags of the finished sample |
| col_cnt | output | COL_W | Saturating count of dropped selections |

## Verification
The assertions assume known strobe values after reset. They also assume that a retire is presented only once, through the retire port, for each identifier that the pipeline really retires. The stimulus keeps to this by issuing the retire of a tagged operation only while the bench's own model holds it as pending. Its only other retires are deliberately mismatched identifiers and the retire of an identifier that was cancelled. Configuration fields change only while `en` is low, so every pick inside one sweep point uses one interval and one filter threshold. Perturbation is then checked as a range and a spread, not cycle by cycle.

// File: rtl/osel_pkg.sv
package osel_pkg;

    localparam int unsigned RND_W = 16;
    localparam logic [RND_W-1:0] RND_SEED = 16'hACE1;
    localparam logic [RND_W-1:0] RND_POLY = 16'hB400;

    typedef enum logic {
        TRK_IDLE = 1'b0,
        TRK_BUSY = 1'b1
    } trk_state_e;

    // One step of a right-shifting Galois LFSR.
    function automatic logic [RND_W-1:0] rnd_step(input logic [RND_W-1:0] s);
        return s[0] ? ((s >> 1) ^ RND_POLY) : (s >> 1);
    endfunction

    // Mask with the w lowest bits set.
    function automatic logic [RND_W-1:0] low_mask(input int unsigned w);
        logic [RND_W-1:0] m;
        m = '0;
        for (int i = 0; i < RND_W; i++) begin
            if (i < w) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/osel_lfsr.sv
module osel_lfsr
    import osel_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    output logic [RND_W-1:0] rnd
);
    logic [RND_W-1:0] state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= RND_SEED;
        end else if (adv) begin
            state <= rnd_step(state);
        end
    end

    assign rnd = state;
endmodule

// File: rtl/osel_interval.sv
module osel_interval
    import osel_pkg::*;
#(
    parameter int unsigned IVL_W      = 16,
    parameter int unsigned MAX_PERT_W = 8,
    localparam int unsigned PW_W      = $clog2(MAX_PERT_W + 1),
    localparam int unsigned CNT_W     = IVL_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             dec_vld,
    input  logic [IVL_W-1:0] cfg_interval,
    input  logic [PW_W-1:0]  cfg_pert_w,
    input  logic [RND_W-1:0] rnd,
    output logic             hit,
    output logic             rnd_adv
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] reload;
    logic [CNT_W-1:0] pert;
    logic [IVL_W-1:0] ivl_eff;
    logic [RND_W-1:0] pmask;
    int unsigned      pw_eff;

    always_comb begin
        pw_eff  = (int'(cfg_pert_w) > int'(MAX_PERT_W)) ? MAX_PERT_W : int'(cfg_pert_w);
        pmask   = low_mask(pw_eff);
        pert    = CNT_W'(rnd & pmask);
        ivl_eff = (cfg_interval == '0) ? IVL_W'(1) : cfg_interval;
        reload  = {1'b0, ivl_eff} + pert;
    end

    assign hit     = en && dec_vld && (cnt == CNT_W'(1));
    assign rnd_adv = !en || hit;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt <= reload;
        end else if (hit) begin
            cnt <= reload;
        end else if (dec_vld) begin
            cnt <= cnt - CNT_W'(1);
        end
    end
endmodule

// File: rtl/osel_satcnt.sv
module osel_satcnt #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (inc && (q != '1)) begin
            q <= q + W'(1);
        end
    end
endmodule

// File: rtl/osel_tracker.sv
module osel_tracker
    import osel_pkg::*;
#(
    parameter int unsigned ID_W  = 6,
    parameter int unsigned EVT_W = 4,
    parameter int unsigned LAT_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             hit,
    input  logic [ID_W-1:0]  dec_id,
    input  logic             ret_vld,
    input  logic [ID_W-1:0]  ret_id,
    input  logic [EVT_W-1:0] ret_evt,
    input  logic [LAT_W-1:0] cfg_min_lat,
    output logic             tag_vld,
    output logic [ID_W-1:0]  tag_id,
    output logic             smp_vld,
    output logic             disc_vld,
    output logic [ID_W-1:0]  smp_id,
    output logic [LAT_W-1:0] smp_lat,
    output logic [EVT_W-1:0] smp_evt,
    output logic             collide
);
    typedef struct packed {
        logic [ID_W-1:0]  id;
        logic [LAT_W-1:0] lat;
        logic [EVT_W-1:0] evt;
    } smp_rec_t;

    localparam logic [LAT_W-1:0] LAT_MAX = '1;

    trk_state_e       st;
    logic [ID_W-1:0]  trk_id;
    logic [LAT_W-1:0] lat;
    smp_rec_t         rec_d, rec_q;
    logic             retiring, free_slot, take, pass;

    always_comb begin
        retiring  = (st == TRK_BUSY) && ret_vld && (ret_id == trk_id);
        free_slot = (st == TRK_IDLE) || retiring;
        take      = hit && free_slot;
        collide   = hit && !free_slot;
        pass      = (lat >= cfg_min_lat);
        rec_d     = '{id: trk_id, lat: lat, evt: ret_evt};
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            st       <= TRK_IDLE;
            trk_id   <= '0;
            lat      <= '0;
            tag_vld  <= 1'b0;
            tag_id   <= '0;
            smp_vld  <= 1'b0;
            disc_vld <= 1'b0;
            rec_q    <= '0;
        end else begin
            tag_vld  <= take;
            smp_vld  <= retiring && pass;
            disc_vld <= retiring && !pass;
            if (take) tag_id <= dec_id;
            if (retiring) rec_q <= rec_d;
            if (take) begin
                st     <= TRK_BUSY;
                trk_id <= dec_id;
                lat    <= LAT_W'(1);
            end else if (retiring) begin
                st <= TRK_IDLE;
            end else if ((st == TRK_BUSY) && (lat != LAT_MAX)) begin
                lat <= lat + LAT_W'(1);
            end
        end
    end

    assign smp_id  = rec_q.id;
    assign smp_lat = rec_q.lat;
    assign smp_evt = rec_q.evt;
endmodule

// File: rtl/op_sample_sel.sv
module op_sample_sel
    import osel_pkg::*;
#(
    parameter int unsigned IVL_W      = 16,
    parameter int unsigned MAX_PERT_W = 8,
    parameter int unsigned ID_W       = 6,
    parameter int unsigned EVT_W      = 4,
    parameter int unsigned LAT_W      = 10,
    parameter int unsigned COL_W      = 8,
    localparam int unsigned PW_W      = $clog2(MAX_PERT_W + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [IVL_W-1:0] cfg_interval,
    input  logic [PW_W-1:0]  cfg_pert_w,
    input  logic [LAT_W-1:0] cfg_min_lat,
    input  logic             dec_vld,
    input  logic [ID_W-1:0]  dec_id,
    input  logic             ret_vld,
    input  logic [ID_W-1:0]  ret_id,
    input  logic [EVT_W-1:0] ret_evt,
    output logic             tag_vld,
    output logic [ID_W-1:0]  tag_id,
    output logic             smp_vld,
    output logic             disc_vld,
    output logic [ID_W-1:0]  smp_id,
    output logic [LAT_W-1:0] smp_lat,
    output logic [EVT_W-1:0] smp_evt,
    output logic [COL_W-1:0] col_cnt
);
    logic [RND_W-1:0] rnd;
    logic             rnd_adv;
    logic             hit;
    logic             collide;

    osel_lfsr u_lfsr (
        .clk (clk),
        .rst (rst),
        .adv (rnd_adv),
        .rnd (rnd)
    );

    osel_interval #(
        .IVL_W      (IVL_W),
        .MAX_PERT_W (MAX_PERT_W)
    ) u_interval (
        .clk          (clk),
        .rst          (rst),
        .en           (en),
        .dec_vld      (dec_vld),
        .cfg_interval (cfg_interval),
        .cfg_pert_w   (cfg_pert_w),
        .rnd          (rnd),
        .hit          (hit),
        .rnd_adv      (rnd_adv)
    );

    osel_tracker #(
        .ID_W  (ID_W),
        .EVT_W (EVT_W),
        .LAT_W (LAT_W)
    ) u_tracker (
        .clk         (clk),
        .rst         (rst),
        .en          (en),
        .hit         (hit),
        .dec_id      (dec_id),
        .ret_vld     (ret_vld),
        .ret_id      (ret_id),
        .ret_evt     (ret_evt),
        .cfg_min_lat (cfg_min_lat),
        .tag_vld     (tag_vld),
        .tag_id      (tag_id),
        .smp_vld     (smp_vld),
        .disc_vld    (disc_vld),
        .smp_id      (smp_id),
        .smp_lat     (smp_lat),
        .smp_evt     (smp_evt),
        .collide     (collide)
    );

    osel_satcnt #(
        .W (COL_W)
    ) u_colcnt (
        .clk (clk),
        .rst (rst),
        .inc (collide),
        .q   (col_cnt)
    );
endmodule

// File: rtl/osel_chk.sv
module osel_chk #(
    parameter int unsigned ID_W  = 6,
    parameter int unsigned EVT_W = 4,
    parameter int unsigned LAT_W = 10,
    parameter int unsigned COL_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic [LAT_W-1:0] cfg_min_lat,
    input logic             dec_vld,
    input logic [ID_W-1:0]  dec_id,
    input logic             ret_vld,
    input logic [ID_W-1:0]  ret_id,
    input logic [EVT_W-1:0] ret_evt,
    input logic             tag_vld,
    input logic [ID_W-1:0]  tag_id,
    input logic             smp_vld,
    input logic             disc_vld,
    input logic [ID_W-1:0]  smp_id,
    input logic [LAT_W-1:0] smp_lat,
    input logic [EVT_W-1:0] smp_evt,
    input logic [COL_W-1:0] col_cnt
);
    // R1
    tag_src_chk: assert property (@(posedge clk) disable iff (rst)
        tag_vld |-> ($past(dec_vld) && (tag_id == $past(dec_id))));

    // R4
    ret_src_chk: assert property (@(posedge clk) disable iff (rst)
        (smp_vld || disc_vld) |-> ($past(ret_vld) && (smp_id == $past(ret_id)) && (smp_evt == $past(ret_evt))));

    // R4
    lat_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        (smp_vld || disc_vld) |-> (smp_lat != '0));

    // R5
    filt_pass_chk: assert property (@(posedge clk) disable iff (rst)
        smp_vld |-> (smp_lat >= $past(cfg_min_lat)));

    // R5
    filt_drop_chk: assert property (@(posedge clk) disable iff (rst)
        disc_vld |-> (smp_lat < $past(cfg_min_lat)));

    // R6
    col_step_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((col_cnt == $past(col_cnt)) || (col_cnt == $past(col_cnt) + COL_W'(1))));

    // R8
    en_off_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> !(tag_vld || smp_vld || disc_vld));

    // R10
    excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(smp_vld && disc_vld));
endmodule

bind op_sample_sel osel_chk #(
    .ID_W  (ID_W),
    .EVT_W (EVT_W),
    .LAT_W (LAT_W),
    .COL_W (COL_W)
) u_osel_chk (
    .clk         (clk),
    .rst         (rst),
    .en          (en),
    .cfg_min_lat (cfg_min_lat),
    .dec_vld     (dec_vld),
    .dec_id      (dec_id),
    .ret_vld     (ret_vld),
    .ret_id      (ret_id),
    .ret_evt     (ret_evt),
    .tag_vld     (tag_vld),
    .tag_id      (tag_id),
    .smp_vld     (smp_vld),
    .disc_vld    (disc_vld),
    .smp_id      (smp_id),
    .smp_lat     (smp_lat),
    .smp_evt     (smp_evt),
    .col_cnt     (col_cnt)
);

// File: tb/test_op_sample_sel.sv
`timescale 1ns/1ps
module test_op_sample_sel;
    localparam int IVL_W = 16;
    localparam int ID_W  = 6;
    localparam int EVT_W = 4;
    localparam int LAT_W = 10;
    localparam int COL_W = 8;
    localparam int PW_W  = 4;
    localparam int ID_N  = 1 << ID_W;
    localparam int LAT_M = (1 << LAT_W) - 1;
    localparam int COL_M = (1 << COL_W) - 1;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             en = 1'b0;
    logic [IVL_W-1:0] cfg_interval = '0;
    logic [PW_W-1:0]  cfg_pert_w = '0;
    logic [LAT_W-1:0] cfg_min_lat = '0;
    logic             dec_vld = 1'b0;
    logic [ID_W-1:0]  dec_id = '0;
    logic             ret_vld = 1'b0;
    logic [ID_W-1:0]  ret_id = '0;
    logic [EVT_W-1:0] ret_evt = '0;
    logic             tag_vld;
    logic [ID_W-1:0]  tag_id;
    logic             smp_vld;
    logic             disc_vld;
    logic [ID_W-1:0]  smp_id;
    logic [LAT_W-1:0] smp_lat;
    logic [EVT_W-1:0] smp_evt;
    logic [COL_W-1:0] col_cnt;

    op_sample_sel i_op_sample_sel (
        .clk (clk), .rst (rst), .en (en),
        .cfg_interval (cfg_interval), .cfg_pert_w (cfg_pert_w), .cfg_min_lat (cfg_min_lat),
        .dec_vld (dec_vld), .dec_id (dec_id),
        .ret_vld (ret_vld), .ret_id (ret_id), .ret_evt (ret_evt),
        .tag_vld (tag_vld), .tag_id (tag_id),
        .smp_vld (smp_vld), .disc_vld (disc_vld),
        .smp_id (smp_id), .smp_lat (smp_lat), .smp_evt (smp_evt),
        .col_cnt (col_cnt)
    );

    always #5 clk = ~clk;

    int nchk = 0;
    int nfail = 0;
    bit done = 0;
    int cyc = 0;
    bit exact = 1;

    // bench model of the requirements
    int m_cnt, m_id, m_lat, m_col;
    bit m_busy;

    function automatic int eff_ivl();
        return (cfg_interval == 0) ? 1 : int'(cfg_interval);
    endfunction

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // One clock: model computes expectations from the inputs now applied.
    task automatic step(input string base);
        bit e_tag, e_smp, e_disc, sel, retiring, free_s;
        int e_tid, e_lat, e_sid, e_evt;
        string treq;
        e_tag = 0; e_smp = 0; e_disc = 0; e_tid = 0; e_lat = 0; e_sid = 0; e_evt = 0;
        treq = base;
        if (rst) begin
            m_busy = 0; m_cnt = eff_ivl(); m_lat = 0; m_col = 0; treq = "R9";
        end else if (!en) begin
            m_busy = 0; m_cnt = eff_ivl(); m_lat = 0; treq = "R8";
        end else begin
            sel      = dec_vld && (m_cnt == 1);
            retiring = m_busy && ret_vld && (int'(ret_id) == m_id);
            free_s   = !m_busy || retiring;
            e_tag    = sel && free_s;
            e_tid    = int'(dec_id);
            e_smp    = retiring && (m_lat >= int'(cfg_min_lat));
            e_disc   = retiring && (m_lat < int'(cfg_min_lat));
            e_lat    = m_lat; e_sid = m_id; e_evt = int'(ret_evt);
            if (sel && !free_s) begin
                treq = "R6";
                if (m_col < COL_M) m_col++;
            end else if (sel && retiring) begin
                treq = "R7";
            end
            if (sel) m_cnt = eff_ivl();
            else if (dec_vld) m_cnt--;
            if (e_tag) begin
                m_busy = 1; m_id = int'(dec_id); m_lat = 1;
            end else if (retiring) begin
                m_busy = 0;
            end else if (m_busy && m_lat < LAT_M) begin
                m_lat++;
            end
        end
        @(posedge clk);
        #1;
        cyc++;
        if (exact) begin
            chk(tag_vld == e_tag, treq, "tag_vld", int'(tag_vld), int'(e_tag));
            if (e_tag) chk(int'(tag_id) == e_tid, treq, "tag_id", int'(tag_id), e_tid);
            chk(smp_vld == e_smp, "R5", "smp_vld", int'(smp_vld), int'(e_smp));
            chk(disc_vld == e_disc, "R5", "disc_vld", int'(disc_vld), int'(e_disc));
            chk(!(smp_vld && disc_vld), "R10", "smp&disc", 1, 0);
            if (e_smp || e_disc) begin
                chk(int'(smp_lat) == e_lat, "R4", "smp_lat", int'(smp_lat), e_lat);
                chk(int'(smp_id) == e_sid, "R4", "smp_id", int'(smp_id), e_sid);
                chk(int'(smp_evt) == e_evt, "R5", "smp_evt", int'(smp_evt), e_evt);
            end
            chk(int'(col_cnt) == m_col, (treq == "R9") ? "R9" : "R6", "col_cnt", int'(col_cnt), m_col);
        end
    endtask

    task automatic do_reset();
        rst = 1; en = 0; dec_vld = 0; ret_vld = 0;
        step("R9"); step("R9");
        rst = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    initial begin
        int smin, smax, last, ntag, old_id;
        cfg_interval = 16'd3;
        do_reset();
        // R9: reset state observed at the ports
        chk(!tag_vld && !smp_vld && !disc_vld, "R9", "pulses", int'(tag_vld | smp_vld | disc_vld), 0);
        chk(col_cnt == 0, "R9", "col_cnt", int'(col_cnt), 0);

        // Near-exhaustive sweep: interval, retire delay, threshold, decode pattern
        for (int iv = 0; iv < 6; iv++) begin
            for (int wl = 1; wl < 5; wl++) begin
                for (int ml = 0; ml < 5; ml++) begin
                    for (int pat = 0; pat < 3; pat++) begin
                        en = 0; dec_vld = 0; ret_vld = 0;
                        cfg_interval = IVL_W'(iv);
                        cfg_min_lat  = LAT_W'(ml);
                        cfg_pert_w   = '0;
                        step("R8");
                        en = 1;
                        for (int k = 0; k < 30; k++) begin
                            dec_vld = (pat == 0) ? 1'b1 : (pat == 1) ? ((k % 2) == 0) : ((k % 3) != 2);
                            dec_id  = ID_W'(cyc % ID_N);
                            ret_evt = EVT_W'(cyc % 16);
                            if (m_busy && m_lat >= wl) begin
                                ret_vld = 1; ret_id = ID_W'(m_id);
                            end else if (m_busy && (k % 5) == 3) begin
                                ret_vld = 1; ret_id = ID_W'((m_id + 1) % ID_N);   // R4: foreign id
                            end else begin
                                ret_vld = 0;
                            end
                            step((pat == 0) ? "R1" : "R2");
                        end
                    end
                end
            end
        end

        // R8: cancel an in-flight sample, then retire its id
        en = 0; ret_vld = 0; dec_vld = 0;
        cfg_interval = 16'd2; cfg_min_lat = '0;
        step("R8");
        en = 1;
        old_id = -1;
        for (int k = 0; k < 6 && old_id < 0; k++) begin
            dec_vld = 1; dec_id = ID_W'(40 + k);
            step("R1");
            if (tag_vld) old_id = int'(tag_id);
        end
        chk(old_id >= 0, "R8", "tag seen", old_id, 41);
        dec_vld = 0; en = 0;
        step("R8");
        en = 1;
        for (int k = 0; k < 4; k++) begin
            ret_vld = 1; ret_id = ID_W'(old_id); ret_evt = 4'h5;
            step("R8");
            chk(!smp_vld && !disc_vld, "R8", "cancelled retire", int'(smp_vld | disc_vld), 0);
        end
        ret_vld = 0;

        // R3: perturbed spacing with interval 4 and 3 random bits
        exact = 0;
        en = 0; cfg_interval = 16'd4; cfg_pert_w = 4'd3;
        step("R3");
        en = 1;
        smin = 1000; smax = 0; last = -1; ntag = 0;
        for (int k = 0; k < 600; k++) begin
            dec_vld = 1; dec_id = ID_W'(k % ID_N);
            step("R3");
            ret_vld = 0;
            if (tag_vld) begin
                if (last >= 0) begin
                    chk((k - last) >= 4 && (k - last) <= 11, "R3", "spacing", k - last, 4);
                    if ((k - last) < smin) smin = k - last;
                    if ((k - last) > smax) smax = k - last;
                end
                last = k; ntag++;
                ret_vld = 1; ret_id = tag_id;
            end
        end
        chk(ntag > 40, "R3", "tag count", ntag, 41);
        chk(smax > smin, "R3", "spacing spread", smax - smin, 1);

        done = 1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule